// File: doc/BRIEF.md
# Programmable Address Decode Window Bank

This block steers CPU-side 32-bit addresses to downstream targets through a bank of programmable decode windows. Each window holds a base, a power-of-two size (stored as size minus one, in 64 KB units), a 4-bit target code, an 8-bit attribute byte and an enable. For every incoming address, all windows are compared in parallel. The lowest-numbered matching window then supplies the hit flag, the target, the attribute and a 64-bit translated address.

The first four windows can relocate the address. They replace the window-aligned upper bits with a programmed remap value and supply a programmed upper word. All other windows, and a miss, pass the 32-bit address through with a zero upper word. The windows are programmed through a simple single-cycle register port. Writes land on the clock edge and reads are combinational. A command write can wipe every window at once. Typical target codes are 0 for DRAM, 1 for the device bus and 4 for PCIe. Typical attributes are 0xE0 for PCIe I/O, 0xE8 for PCIe memory and 0x2F for NAND.

Top module: `addr_win_decoder`

## Requirements
- R1: Eight windows occupy 16-byte slots at reg_addr[6:4]. Within a slot, reg_addr[3:2] selects the field: 0 is control, 1 is base, 2 is remap low and 3 is remap high. Bits 1:0 are ignored.
- R2: The control word holds size-minus-one in bits 31:16, the attribute in 15:8, the target in 7:4 and the enable in bit 0. Bits 3:1 read as zero.
- R3: The base register keeps only bits 31:16. Written bits 15:0 are dropped and read as zero.
- R4: On windows 4 to 7, the remap offsets read as zero, and writing them changes neither readback nor translation.
- R5: Remap low keeps bits 31:16 (low half reads zero). Remap high keeps all 32 bits.
- R6: After reset, every field of every window reads zero and every lookup misses.
- R7: Writing reg_addr 0x80 with data bit 0 set clears all windows on that edge. Writing it with bit 0 clear has no effect, and reg_addr 0x80 reads as zero.
- R8: A window hits when it is enabled and ((addr[31:16] ^ base) & ~size_m1) is zero. A disabled window never hits.
- R9: A hit in window 0 to 3 gives xlat_addr = {remap_hi, (remap_lo & ~size_m1) | (addr[31:16] & size_m1), addr[15:0]}.
- R10: A hit in window 4 to 7 gives xlat_addr = {32'h0, addr}. The low 16 address bits always pass through unchanged.
- R11: When several windows hit, the lowest-numbered one supplies target, attribute and translation.
- R12: With no hit, win_miss is 1, win_hit is 0, target and attribute are zero, and xlat_addr = {32'h0, addr}.
- R13: Lookup is combinational from cpu_addr. A register write changes the lookup only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, captured on the rising edge |
| reg_addr | input | 8 | Register byte address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| cpu_addr | input | 32 | Address to decode |
| win_hit | output | 1 | Some enabled window matches |
| win_miss | output | 1 | No window matches |
| win_tgt | output | 4 | Target code of the winning window |
| win_attr | output | 8 | Attribute byte of the winning window |
| xlat_addr | output | 64 | Translated address |

## Verification
The hardest case to reach from the ports is overlap priority, where two enabled windows claim the same address. The stimulus sets up this case deliberately. It programs two windows of different sizes over a shared region, then probes one address inside both and one address inside only the larger window. That shows the lower index winning and the higher index still reachable. A remap-capable window with a size above 64 KB is also probed, so that the merge of remap bits and passed-through bits inside the size mask is visible in the translated address.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned XLAT_W  = 64;
    localparam int unsigned GRAN_W  = 16;
    localparam int unsigned PAGE_W  = ADDR_W - GRAN_W;
    localparam int unsigned TGT_W   = 4;
    localparam int unsigned ATTR_W  = 8;

    localparam logic [1:0] FLD_CTRL  = 2'd0;
    localparam logic [1:0] FLD_BASE  = 2'd1;
    localparam logic [1:0] FLD_RLO   = 2'd2;
    localparam logic [1:0] FLD_RHI   = 2'd3;

    typedef struct packed {
        logic [PAGE_W-1:0] size_m1;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  tgt;
        logic              en;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] rlo;
        logic [ADDR_W-1:0] rhi;
    } win_cfg_t;

endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
    import addr_win_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 8,
    parameter int unsigned NUM_REMAP = 4,
    parameter int unsigned RA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output win_cfg_t          cfg [NUM_WIN]
);

    localparam int unsigned SLOT_W = RA_W - 5;
    localparam logic [RA_W-1:0] CLR_ADDR = RA_W'(1) << (RA_W - 1);

    logic              cmd_space;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        fld;
    logic              wipe;

    assign cmd_space = reg_addr[RA_W-1];
    assign slot      = reg_addr[RA_W-2:4];
    assign fld       = reg_addr[3:2];
    assign wipe      = reg_we && (reg_addr == CLR_ADDR) && reg_wdata[0];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        win_cfg_t cfg_q;
        logic     sel;

        assign sel    = reg_we && !cmd_space && (slot == SLOT_W'(w));
        assign cfg[w] = cfg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (wipe) begin
                cfg_q <= '0;
            end else if (sel) begin
                unique case (fld)
                    FLD_CTRL: begin
                        cfg_q.size_m1 <= reg_wdata[31:16];
                        cfg_q.attr    <= reg_wdata[15:8];
                        cfg_q.tgt     <= reg_wdata[7:4];
                        cfg_q.en      <= reg_wdata[0];
                    end
                    FLD_BASE: cfg_q.base <= reg_wdata[31:16];
                    FLD_RLO: begin
                        if (w < NUM_REMAP) cfg_q.rlo <= reg_wdata[31:16];
                    end
                    FLD_RHI: begin
                        if (w < NUM_REMAP) cfg_q.rhi <= reg_wdata;
                    end
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!cmd_space) begin
            unique case (fld)
                FLD_CTRL: reg_rdata = {cfg[slot].size_m1, cfg[slot].attr,
                                       cfg[slot].tgt, 3'b000, cfg[slot].en};
                FLD_BASE: reg_rdata = {cfg[slot].base, 16'h0000};
                FLD_RLO:  reg_rdata = {cfg[slot].rlo, 16'h0000};
                FLD_RHI:  reg_rdata = cfg[slot].rhi;
            endcase
        end
    end

endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
    import addr_win_pkg::*;
#(
    parameter bit CAN_REMAP = 1'b0
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              hit,
    output logic [XLAT_W-1:0] xlat
);

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] diff;

    assign page = cpu_addr[ADDR_W-1:GRAN_W];
    assign diff = (page ^ cfg.base) & ~cfg.size_m1;
    assign hit  = cfg.en && (diff == '0);

    if (CAN_REMAP) begin : g_remap
        assign xlat = {cfg.rhi,
                       (cfg.rlo & ~cfg.size_m1) | (page & cfg.size_m1),
                       cpu_addr[GRAN_W-1:0]};
    end else begin : g_pass
        assign xlat = {{(XLAT_W-ADDR_W){1'b0}}, cpu_addr};
    end

endmodule

// File: rtl/addr_win_prio.sv
module addr_win_prio
    import addr_win_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8
) (
    input  logic [NUM_WIN-1:0] hits,
    input  win_cfg_t           cfg [NUM_WIN],
    input  logic [XLAT_W-1:0]  xlat [NUM_WIN],
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               any_hit,
    output logic [TGT_W-1:0]   tgt,
    output logic [ATTR_W-1:0]  attr,
    output logic [XLAT_W-1:0]  xlat_out
);

    always_comb begin
        any_hit  = |hits;
        tgt      = '0;
        attr     = '0;
        xlat_out = {{(XLAT_W-ADDR_W){1'b0}}, cpu_addr};
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                tgt      = cfg[i].tgt;
                attr     = cfg[i].attr;
                xlat_out = xlat[i];
            end
        end
    end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import addr_win_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 8,
    parameter int unsigned NUM_REMAP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] cpu_addr,
    output logic        win_hit,
    output logic        win_miss,
    output logic [3:0]  win_tgt,
    output logic [7:0]  win_attr,
    output logic [63:0] xlat_addr
);

    localparam int unsigned RA_W = $clog2(NUM_WIN) + 5;

    win_cfg_t           cfg  [NUM_WIN];
    logic [XLAT_W-1:0]  xlat [NUM_WIN];
    logic [NUM_WIN-1:0] hits;
    logic               any_hit;

    addr_win_regs #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .RA_W      (RA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr[RA_W-1:0]),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        addr_win_match #(
            .CAN_REMAP (w < NUM_REMAP)
        ) u_match (
            .cfg      (cfg[w]),
            .cpu_addr (cpu_addr),
            .hit      (hits[w]),
            .xlat     (xlat[w])
        );
    end

    addr_win_prio #(
        .NUM_WIN (NUM_WIN)
    ) u_prio (
        .hits     (hits),
        .cfg      (cfg),
        .xlat     (xlat),
        .cpu_addr (cpu_addr),
        .any_hit  (any_hit),
        .tgt      (win_tgt),
        .attr     (win_attr),
        .xlat_out (xlat_addr)
    );

    assign win_hit  = any_hit;
    assign win_miss = !any_hit;

endmodule

// File: rtl/addr_win_checker.sv
module addr_win_checker #(
    parameter int unsigned NUM_REMAP = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] cpu_addr,
    input logic        win_hit,
    input logic        win_miss,
    input logic [3:0]  win_tgt,
    input logic [7:0]  win_attr,
    input logic [63:0] xlat_addr
);

    a_r12_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        win_miss |-> (!win_hit && win_tgt == 4'h0 && win_attr == 8'h00));

    a_r12_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        win_miss |-> (xlat_addr == {32'h0, cpu_addr}));

    a_r10_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_addr[15:0] == cpu_addr[15:0]);

    a_r7_wipe_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h80 && reg_wdata[0]) |=> win_miss);

    a_r4_no_remap_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_addr[7] && reg_addr[6:4] >= 3'(NUM_REMAP) && reg_addr[3])
            |-> (reg_rdata == 32'h0));

    a_r3_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_addr[7] && reg_addr[3:2] == 2'b01) |-> (reg_rdata[15:0] == 16'h0));

endmodule

bind addr_win_decoder addr_win_checker #(
    .NUM_REMAP (NUM_REMAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_addr  (cpu_addr),
    .win_hit   (win_hit),
    .win_miss  (win_miss),
    .win_tgt   (win_tgt),
    .win_attr  (win_attr),
    .xlat_addr (xlat_addr)
);

// File: tb/addr_win_decoder_tb.sv
module addr_win_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = 32'h0;
    logic        win_hit;
    logic        win_miss;
    logic [3:0]  win_tgt;
    logic [7:0]  win_attr;
    logic [63:0] xlat_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    addr_win_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_addr  (cpu_addr),
        .win_hit   (win_hit),
        .win_miss  (win_miss),
        .win_tgt   (win_tgt),
        .win_attr  (win_attr),
        .xlat_addr (xlat_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic hit,
                        input logic [3:0] t, input logic [7:0] at, input logic [63:0] x);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk({req, " hit"},  {63'h0, win_hit},  {63'h0, hit});
        chk({req, " miss"}, {63'h0, win_miss}, {63'h0, !hit});
        chk({req, " tgt"},  {60'h0, win_tgt},  {60'h0, t});
        chk({req, " attr"}, {56'h0, win_attr}, {56'h0, at});
        chk({req, " xlat"}, xlat_addr, x);
    endtask

    task automatic t_reset;
        look("R6 reset lookup", 32'hE000_0000, 1'b0, 4'h0, 8'h00, 64'h0000_0000_E000_0000);
        rd_chk("R6 reset ctrl w0", 8'h00, 32'h0);
        rd_chk("R6 reset rhi w3", 8'h3C, 32'h0);
    endtask

    task automatic t_fields;
        wr(8'h20, 32'h00FF_2F1F);
        rd_chk("R2 ctrl layout w2", 8'h20, 32'h00FF_2F11);
        wr(8'h24, 32'h1234_5678);
        rd_chk("R3 base low dropped", 8'h24, 32'h1234_0000);
        rd_chk("R1 byte bits ignored", 8'h27, 32'h1234_0000);
        wr(8'h18, 32'hABCD_EF01);
        rd_chk("R5 remap lo", 8'h18, 32'hABCD_0000);
        wr(8'h1C, 32'h8765_4321);
        rd_chk("R5 remap hi", 8'h1C, 32'h8765_4321);
        rd_chk("R7 command reads zero", 8'h80, 32'h0);
        wr(8'h20, 32'h0);
    endtask

    task automatic t_remap;
        wr(8'h04, 32'hE000_0000);
        wr(8'h08, 32'hC000_0000);
        wr(8'h0C, 32'h0000_0002);
        wr(8'h00, 32'h000F_E041);
        look("R9 remap hit", 32'hE00A_1234, 1'b1, 4'h4, 8'hE0, 64'h0000_0002_C00A_1234);
        look("R8 outside size", 32'hE010_0000, 1'b0, 4'h0, 8'h00, 64'h0000_0000_E010_0000);
        wr(8'h00, 32'h000F_E040);
        look("R8 disabled", 32'hE00A_1234, 1'b0, 4'h0, 8'h00, 64'h0000_0000_E00A_1234);
    endtask

    task automatic t_noremap;
        wr(8'h54, 32'h9000_0000);
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h5C, 32'hFFFF_FFFF);
        rd_chk("R4 w5 remap lo", 8'h58, 32'h0);
        rd_chk("R4 w5 remap hi", 8'h5C, 32'h0);
        wr(8'h50, 32'h00FF_2F11);
        look("R10 R4 pass-through", 32'h9012_3456, 1'b1, 4'h1, 8'h2F, 64'h0000_0000_9012_3456);
    endtask

    task automatic t_prio;
        wr(8'h34, 32'h9000_0000);
        wr(8'h38, 32'h5000_0000);
        wr(8'h3C, 32'h0000_00AA);
        wr(8'h30, 32'h0FFF_E841);
        look("R11 low index wins", 32'h9012_3456, 1'b1, 4'h4, 8'hE8, 64'h0000_00AA_5012_3456);
        look("R11 larger only", 32'h9F00_0000, 1'b1, 4'h4, 8'hE8, 64'h0000_00AA_5F00_0000);
        wr(8'h30, 32'h0);
        look("R11 next window wins", 32'h9012_3456, 1'b1, 4'h1, 8'h2F, 64'h0000_0000_9012_3456);
    endtask

    task automatic t_timing;
        @(negedge clk);
        cpu_addr = 32'h7000_1111;
        reg_we = 1'b1; reg_addr = 8'h74; reg_wdata = 32'h7000_0000;
        @(negedge clk);
        reg_addr = 8'h70; reg_wdata = 32'h0000_0011;
        #1;
        chk("R13 before edge", {63'h0, win_hit}, 64'h0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R13 after edge", {63'h0, win_hit}, 64'h1);
        chk("R13 tgt after edge", {60'h0, win_tgt}, 64'h1);
    endtask

    task automatic t_clear;
        wr(8'h80, 32'hFFFF_FFFE);
        look("R7 no-op clear", 32'h9012_3456, 1'b1, 4'h1, 8'h2F, 64'h0000_0000_9012_3456);
        wr(8'h80, 32'h0000_0001);
        look("R7 wiped", 32'h9012_3456, 1'b0, 4'h0, 8'h00, 64'h0000_0000_9012_3456);
        rd_chk("R7 wiped base w5", 8'h54, 32'h0);
        rd_chk("R7 wiped rhi w0", 8'h0C, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_remap();
        t_noremap();
        t_prio();
        t_timing();
        t_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule